// File: doc/BRIEF.md
# Clock Lock Detection Monitor

This block watches a feedback clock against a reference clock and decides when the two have reached frequency lock. A window timer in the reference domain marks a fixed run of reference cycles. A counter in the feedback domain counts feedback cycles over the same span. At each window end the feedback count crosses into the reference domain through a toggle handshake. There it is compared with the window length.

Lock is declared after a run of consecutive windows whose count lies within the lock tolerance. Once locked, the block keeps measuring. A single window outside the wider loss tolerance ends the lock, and so does a window whose count never arrived. Frequency modulation widens both tolerances. Bypass mode holds the lock flag low, and a change of the feedback divider restarts acquisition. Each time the lock flag falls, the block can raise an interrupt request, raise a reset request, or do nothing.

Top module: `lock_monitor`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `lock`, `lock_sticky`, `irq` and `rst_req` are all 0.
- R2: `lock` rises only after LOCK_RUN (default 4) consecutive counted windows lie within tolerance. The first window after reset is discarded. After a lock loss, three windows of good feedback are never enough to relock.
- R3: With `fm_en` = 0 the lock tolerance is ±LOCK_TOL (default 1) counts around WIN_CYCLES (default 64). A steady count 2 to 3 away from it never locks.
- R4: With `fm_en` = 1 the lock tolerance widens to ±LOCK_TOL_FM (default 4), so the same 2 to 3 count offset does lock. The loss tolerance widens to ±LOSS_TOL_FM (default 8).
- R5: While locked, one window whose count differs from WIN_CYCLES by more than the active loss tolerance (LOSS_TOL = 2 without modulation) clears `lock`. A window whose count was not delivered before the next window ended also clears `lock`.
- R6: `lock_sticky` is set only by the first rise of `lock` after reset. It is cleared by a loss of lock (R5) and is not set again when lock returns.
- R7: A one-cycle `div_change` pulse clears `lock` in the next cycle and leaves `lock_sticky` unchanged. Acquisition then restarts from zero good windows.
- R8: While `bypass` is 1, `lock` is 0 from the next cycle onward and never rises.
- R9: `lol_action` selects the action on every fall of `lock`. 2'b01 gives a one-cycle `irq` pulse. 2'b10 gives a one-cycle `rst_req` pulse. 2'b00 and 2'b11 give neither. The pulse coincides with the first cycle in which `lock` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all control inputs and all outputs are in this domain |
| fb_clk | input | 1 | Feedback clock under measurement |
| rst | input | 1 | Synchronous active-high reset (reference domain) |
| bypass | input | 1 | Loop bypassed; lock is suppressed |
| fm_en | input | 1 | Frequency modulation active; selects the wide tolerances |
| div_change | input | 1 | One-cycle pulse: feedback divider was rewritten |
| lol_action | input | 2 | Action on lock fall: 01 interrupt, 10 reset request, else none |
| lock | output | 1 | Live lock flag |
| lock_sticky | output | 1 | Lock-reached flag, cleared by loss of lock |
| irq | output | 1 | One-cycle interrupt request on lock fall |
| rst_req | output | 1 | One-cycle reset request on lock fall |

## Verification
The main function is tried with four feedback periods: equal to the reference, about 4% slow, about 4% fast, and 20% slow. Each is run with modulation on and off. The equal period must lock in both modes and the 20% slow one in neither. The two small offsets lock only with modulation on, which separates the narrow tolerance from the wide one. Loss is provoked by switching a locked loop to the far-off period under each action code, which separates interrupt, reset request and silence. A restored clock is sampled three windows later to show that the run length is enforced again. Divider-change and bypass are exercised from the locked state to tell a restart apart from a loss, using the sticky flag.

// File: rtl/lkm_pkg.sv
package lkm_pkg;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'b00,
    ACT_IRQ   = 2'b01,
    ACT_RESET = 2'b10,
    ACT_OFF   = 2'b11
  } lol_action_e;

  function automatic int unsigned abs_gap(input int unsigned a, input int unsigned b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

endpackage

// File: rtl/lkm_sync.sv
module lkm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/lkm_win_timer.sv
module lkm_win_timer #(
  parameter int WIN_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  output logic win_end
);
  localparam int TW = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(WIN_CYCLES - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      win_end <= 1'b0;
    end else begin
      win_end <= (cnt == LAST);
      cnt     <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lkm_cdc_count.sv
module lkm_cdc_count #(
  parameter int CNT_W  = 8,
  parameter int STAGES = 2
) (
  input  logic             ref_clk,
  input  logic             ref_rst,
  input  logic             fb_clk,
  input  logic             win_end,
  output logic             smp_valid,
  output logic [CNT_W-1:0] smp_cnt,
  output logic             smp_miss
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // feedback-domain reset, released a few feedback edges after the reference one
  logic fb_rst;
  lkm_sync #(.STAGES(STAGES)) u_rst_sync (
    .clk(fb_clk), .rst(1'b0), .d(ref_rst), .q(fb_rst)
  );

  // reference side: request toggle, acknowledge detection
  logic req_tgl, ack_seen, ack_s, primed;
  logic [CNT_W-1:0] fb_hold;

  lkm_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk(ref_clk), .rst(ref_rst), .d(ack_tgl), .q(ack_s)
  );

  always_ff @(posedge ref_clk) begin
    if (ref_rst) begin
      req_tgl   <= 1'b0;
      ack_seen  <= 1'b0;
      primed    <= 1'b0;
      smp_valid <= 1'b0;
      smp_miss  <= 1'b0;
      smp_cnt   <= '0;
    end else begin
      smp_valid <= 1'b0;
      smp_miss  <= 1'b0;
      if (win_end) begin
        if (req_tgl == ack_s) req_tgl  <= ~req_tgl;
        else                  smp_miss <= primed;
      end
      if (ack_s != ack_seen) begin
        ack_seen <= ack_s;
        if (primed) begin
          smp_valid <= 1'b1;
          smp_cnt   <= fb_hold;
        end
        primed <= 1'b1;
      end
    end
  end

  // feedback side: count cycles between snapshots
  logic             req_s, req_seen, ack_tgl;
  logic [CNT_W-1:0] fb_cnt;

  lkm_sync #(.STAGES(STAGES)) u_req_sync (
    .clk(fb_clk), .rst(fb_rst), .d(req_tgl), .q(req_s)
  );

  always_ff @(posedge fb_clk) begin
    if (fb_rst) begin
      req_seen <= 1'b0;
      ack_tgl  <= 1'b0;
      fb_cnt   <= '0;
      fb_hold  <= '0;
    end else if (req_s != req_seen) begin
      req_seen <= req_s;
      fb_hold  <= (fb_cnt == CNT_MAX) ? CNT_MAX : fb_cnt + 1'b1;
      fb_cnt   <= '0;
      ack_tgl  <= req_s;
    end else if (fb_cnt != CNT_MAX) begin
      fb_cnt <= fb_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lkm_judge.sv
module lkm_judge
  import lkm_pkg::*;
#(
  parameter int WIN_CYCLES  = 64,
  parameter int CNT_W       = 8,
  parameter int LOCK_RUN    = 4,
  parameter int LOCK_TOL    = 1,
  parameter int LOCK_TOL_FM = 4,
  parameter int LOSS_TOL    = 2,
  parameter int LOSS_TOL_FM = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bypass,
  input  logic             fm_en,
  input  logic             div_change,
  input  logic [1:0]       lol_action,
  input  logic             smp_valid,
  input  logic [CNT_W-1:0] smp_cnt,
  input  logic             smp_miss,
  output logic             lock,
  output logic             lock_sticky,
  output logic             irq,
  output logic             rst_req
);
  localparam int RW = $clog2(LOCK_RUN + 1);
  localparam logic [RW-1:0] RUN_LAST = RW'(LOCK_RUN - 1);

  logic [RW-1:0] run, run_n;
  logic          first_done, lock_n, lost;
  int unsigned   gap, lock_tol, loss_tol;
  lol_action_e   act;

  assign act      = lol_action_e'(lol_action);
  assign gap      = abs_gap(int'(smp_cnt), WIN_CYCLES);
  assign lock_tol = fm_en ? LOCK_TOL_FM : LOCK_TOL;
  assign loss_tol = fm_en ? LOSS_TOL_FM : LOSS_TOL;

  always_comb begin
    lock_n = lock;
    run_n  = run;
    lost   = 1'b0;
    if (bypass || div_change) begin
      lock_n = 1'b0;
      run_n  = '0;
    end else if (smp_miss) begin
      lost   = lock;
      lock_n = 1'b0;
      run_n  = '0;
    end else if (smp_valid) begin
      if (lock) begin
        if (gap > loss_tol) begin
          lost   = 1'b1;
          lock_n = 1'b0;
        end
      end else if (gap <= lock_tol) begin
        if (run == RUN_LAST) begin
          lock_n = 1'b1;
          run_n  = '0;
        end else begin
          run_n = run + 1'b1;
        end
      end else begin
        run_n = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock        <= 1'b0;
      lock_sticky <= 1'b0;
      first_done  <= 1'b0;
      run         <= '0;
      irq         <= 1'b0;
      rst_req     <= 1'b0;
    end else begin
      lock    <= lock_n;
      run     <= run_n;
      irq     <= lock && !lock_n && (act == ACT_IRQ);
      rst_req <= lock && !lock_n && (act == ACT_RESET);
      if (lost) begin
        lock_sticky <= 1'b0;
      end else if (lock_n && !lock && !first_done) begin
        lock_sticky <= 1'b1;
        first_done  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lock_monitor.sv
module lock_monitor #(
  parameter int WIN_CYCLES  = 64,
  parameter int LOCK_RUN    = 4,
  parameter int LOCK_TOL    = 1,
  parameter int LOCK_TOL_FM = 4,
  parameter int LOSS_TOL    = 2,
  parameter int LOSS_TOL_FM = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       ref_clk,
  input  logic       fb_clk,
  input  logic       rst,
  input  logic       bypass,
  input  logic       fm_en,
  input  logic       div_change,
  input  logic [1:0] lol_action,
  output logic       lock,
  output logic       lock_sticky,
  output logic       irq,
  output logic       rst_req
);
  localparam int CNT_W = $clog2(WIN_CYCLES) + 2;

  logic             win_end, smp_valid, smp_miss;
  logic [CNT_W-1:0] smp_cnt;

  lkm_win_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
    .clk(ref_clk), .rst(rst), .win_end(win_end)
  );

  lkm_cdc_count #(.CNT_W(CNT_W), .STAGES(SYNC_STAGES)) u_xfer (
    .ref_clk(ref_clk), .ref_rst(rst), .fb_clk(fb_clk), .win_end(win_end),
    .smp_valid(smp_valid), .smp_cnt(smp_cnt), .smp_miss(smp_miss)
  );

  lkm_judge #(
    .WIN_CYCLES(WIN_CYCLES), .CNT_W(CNT_W), .LOCK_RUN(LOCK_RUN),
    .LOCK_TOL(LOCK_TOL), .LOCK_TOL_FM(LOCK_TOL_FM),
    .LOSS_TOL(LOSS_TOL), .LOSS_TOL_FM(LOSS_TOL_FM)
  ) u_judge (
    .clk(ref_clk), .rst(rst), .bypass(bypass), .fm_en(fm_en),
    .div_change(div_change), .lol_action(lol_action),
    .smp_valid(smp_valid), .smp_cnt(smp_cnt), .smp_miss(smp_miss),
    .lock(lock), .lock_sticky(lock_sticky), .irq(irq), .rst_req(rst_req)
  );
endmodule

// File: rtl/lkm_checker.sv
module lkm_checker (
  input logic ref_clk,
  input logic rst,
  input logic bypass,
  input logic div_change,
  input logic lock,
  input logic lock_sticky,
  input logic irq,
  input logic rst_req
);
  // R1
  reset_clear_chk: assert property (@(posedge ref_clk)
    rst |=> (!lock && !lock_sticky && !irq && !rst_req));

  // R8
  bypass_nolock_chk: assert property (@(posedge ref_clk) disable iff (rst)
    bypass |=> !lock);

  // R7
  divchg_unlock_chk: assert property (@(posedge ref_clk) disable iff (rst)
    div_change |=> !lock);

  // R6
  sticky_rise_chk: assert property (@(posedge ref_clk) disable iff (rst)
    $rose(lock_sticky) |-> $rose(lock));

  // R9
  irq_on_fall_chk: assert property (@(posedge ref_clk) disable iff (rst)
    irq |-> (!lock && $past(lock)));

  // R9
  rstreq_on_fall_chk: assert property (@(posedge ref_clk) disable iff (rst)
    rst_req |-> (!lock && $past(lock)));

  // R9
  irq_single_chk: assert property (@(posedge ref_clk) disable iff (rst)
    irq |=> !irq);

  // R9
  action_excl_chk: assert property (@(posedge ref_clk) disable iff (rst)
    !(irq && rst_req));
endmodule

bind lock_monitor lkm_checker u_chk (
  .ref_clk(ref_clk), .rst(rst), .bypass(bypass), .div_change(div_change),
  .lock(lock), .lock_sticky(lock_sticky), .irq(irq), .rst_req(rst_req)
);

// File: tb/lock_monitor_tb.sv
`timescale 1ns/1ps
module lock_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 64;
  localparam int WD_CYCLES  = 150000;

  logic ref_clk = 1'b0, fb_clk = 1'b0;
  logic rst = 1'b1, bypass = 1'b0, fm_en = 1'b0, div_change = 1'b0;
  logic [1:0] lol_action = 2'b01;
  logic lock, lock_sticky, irq, rst_req;
  real  fb_half = 5.0;
  int   checks = 0, errors = 0, irq_n = 0, rrq_n = 0;

  lock_monitor u_dut (
    .ref_clk(ref_clk), .fb_clk(fb_clk), .rst(rst), .bypass(bypass),
    .fm_en(fm_en), .div_change(div_change), .lol_action(lol_action),
    .lock(lock), .lock_sticky(lock_sticky), .irq(irq), .rst_req(rst_req)
  );

  always #(CLK_PERIOD/2) ref_clk = ~ref_clk;
  initial forever #(fb_half) fb_clk = ~fb_clk;

  always @(negedge ref_clk) begin
    if (irq) irq_n++;
    if (rst_req) rrq_n++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic wait_win(input int n);
    wait_cyc(n * WIN);
  endtask

  task automatic pulse_div();
    div_change = 1'b1;
    wait_cyc(1);
    div_change = 1'b0;
  endtask

  // feedback half-periods: 0 equal, 1 slow ~4%, 2 fast ~4%, 3 slow 20%
  function automatic real half_of(input int idx);
    case (idx)
      0: return 5.0;
      1: return 5.2;
      2: return 4.8;
      default: return 6.0;
    endcase
  endfunction

  // lock criterion per R3/R4: offsets 2..3 lock only with modulation
  function automatic int exp_lock(input int idx, input int fm);
    if (idx == 0) return 1;
    if (idx == 3) return 0;
    return fm;
  endfunction

  initial begin
    int i0, r0;
    void'($urandom(32'd2024));
    wait_cyc(3);
    check("R1 lock in reset", lock, 0);
    check("R1 sticky in reset", lock_sticky, 0);
    check("R1 irq/rst_req in reset", irq | rst_req, 0);
    rst = 1'b0;
    wait_cyc(1);
    check("R1 lock after release", lock, 0);
    check("R1 sticky after release", lock_sticky, 0);

    wait_win(2);
    check("R2 no early lock", lock, 0);
    wait_win(6);
    check("R2 lock reached", lock, 1);
    check("R6 sticky set on first lock", lock_sticky, 1);

    // R7 divider change from locked
    lol_action = 2'b01;
    i0 = irq_n;
    pulse_div();
    wait_cyc(1);
    check("R7 lock cleared", lock, 0);
    check("R7 sticky kept", lock_sticky, 1);
    check("R9 irq on divider fall", irq_n - i0, 1);
    wait_win(8);
    check("R7 relock after change", lock, 1);

    // R5 / R9 loss with interrupt action
    i0 = irq_n; r0 = rrq_n;
    fb_half = half_of(3);
    wait_win(4);
    check("R5 loss clears lock", lock, 0);
    check("R6 sticky cleared by loss", lock_sticky, 0);
    check("R9 irq count", irq_n - i0, 1);
    check("R9 no rst_req for 01", rrq_n - r0, 0);
    fb_half = half_of(0);
    wait_win(3);
    check("R2 three windows not enough", lock, 0);
    wait_win(5);
    check("R2 relock", lock, 1);
    check("R6 sticky not re-set", lock_sticky, 0);

    // R9 reset action
    lol_action = 2'b10;
    i0 = irq_n; r0 = rrq_n;
    fb_half = half_of(3);
    wait_win(4);
    check("R9 rst_req count", rrq_n - r0, 1);
    check("R9 no irq for 10", irq_n - i0, 0);
    fb_half = half_of(0);
    wait_win(8);

    // R9 silent action
    lol_action = 2'b00;
    i0 = irq_n; r0 = rrq_n;
    fb_half = half_of(3);
    wait_win(4);
    check("R5 lock lost silently", lock, 0);
    check("R9 no pulses for 00", (irq_n - i0) + (rrq_n - r0), 0);

    // R3 / R4 tolerance widening
    fb_half = half_of(1);
    fm_en = 1'b0;
    pulse_div();
    wait_win(8);
    check("R3 narrow tolerance rejects", lock, 0);
    fm_en = 1'b1;
    pulse_div();
    wait_win(8);
    check("R4 wide tolerance locks", lock, 1);
    fb_half = half_of(3);
    wait_win(4);
    check("R4 loss beyond wide tolerance", lock, 0);

    // R8 bypass
    fm_en = 1'b0;
    fb_half = half_of(0);
    wait_win(8);
    check("R8 locked before bypass", lock, 1);
    bypass = 1'b1;
    wait_cyc(2);
    check("R8 bypass clears lock", lock, 0);
    for (int k = 0; k < 8; k++) begin
      wait_win(1);
      check("R8 no lock in bypass", lock, 0);
    end
    bypass = 1'b0;
    wait_win(8);
    check("R8 relock after bypass", lock, 1);

    // random mix: R3 R4
    for (int it = 0; it < 10; it++) begin
      int idx, fm;
      idx = int'($urandom % 4);
      fm  = int'($urandom % 2);
      lol_action = 2'($urandom);
      fb_half = half_of(idx);
      fm_en = fm[0];
      pulse_div();
      wait_win(8);
      check(fm ? "R4 random lock" : "R3 random lock", lock, exp_lock(idx, fm));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge ref_clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule